// File: doc/BRIEF.md
# Keystream Session Setup Sequencer

This controller runs one complete session setup on an external bit-serial keystream core. The core has three majority-clocked shift registers. The sequencer drives the core through a 3-bit control word and reads back the core's single output bit.

A session begins when a request is accepted. The sequencer then runs these phases in a fixed order:

1. One clock of synchronous reset.
2. The 64 key bits, with stepping forced on all registers.
3. The 22 frame-number bits, also with stepping forced.
4. 100 clocks whose output is thrown away, with the core stepping under its own majority rule.
5. Two 114-bit output bursts, each captured into its own parallel register.

The key and the frame number are latched at acceptance, so the inputs are free to change once the session is under way.

The request side is a valid/ready handshake:
- `req_ready` is high only while the sequencer is idle.
- A request is accepted on the rising clock edge where `req_valid` and `req_ready` are both high.
- While `req_ready` is low, `req_valid` is ignored and may be held high or toggled freely.

The result side has no back-pressure. `done` pulses for one cycle, and the two burst registers then hold their values until the next session overwrites them.

Top module: `kss_setup_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the sequencer is idle. This holds after reset and again from the cycle in which `done` is high. A request presented while `req_ready` is 0 has no effect.
- R2: In the cycle after acceptance, `core_ctl` is {reset=1, force=0, data=key[0]}, with bit 2 = reset, bit 1 = force and bit 0 = data. The next cycle has reset = 0.
- R3: For the 64 cycles after the reset cycle, `core_ctl` = {0, 1, key[i]} for i = 0 to 63, least significant bit first.
- R4: For the next 22 cycles, `core_ctl` = {0, 1, frame[j]} for j = 0 to 21, least significant bit first.
- R5: For the next 100 cycles, and then for all 228 burst cycles, `core_ctl` = 3'b000.
- R6: The core output is taken once after each burst step, in the cycle that follows that step. Each captured bit enters its register at bit 0 and the register shifts toward the MSB, so the first bit of a burst ends up in bit 113. The first 114 captures form `burst_ab` and the next 114 form `burst_ba`.
- R7: `done` is high for exactly one cycle, 417 cycles after the acceptance edge. That cycle is the one right after the 228th capture.
- R8: A change on `key_in` or `frame_in` after acceptance has no effect on the running session.
- R9: Both burst registers keep their values while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Session request |
| req_ready | output | 1 | High when a request can be taken |
| key_in | input | 64 | Session key |
| frame_in | input | 22 | Frame number |
| core_ctl | output | 3 | {reset, force, data} to the core |
| core_out | input | 1 | Core output bit |
| burst_ab | output | 114 | First captured burst |
| burst_ba | output | 114 | Second captured burst |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `core_out` is a clean registered value that is only meaningful after each core step. They also assume that `rst_n` is held low for at least one edge before any request. The bench keeps within these bounds by driving `core_out` from a behavioural three-register core clocked by the same edge. During a session it changes `req_valid`, `key_in` and `frame_in` at random, and it drops `req_valid` before `req_ready` can return. The expected bursts come from a separate bench function that recomputes the whole session from the key and frame number alone.

// File: rtl/kss_setup_pkg.sv
package kss_setup_pkg;
  localparam int KEY_BITS_D   = 64;
  localparam int FRAME_BITS_D = 22;
  localparam int DISCARD_D    = 100;
  localparam int BURST_BITS_D = 114;
  localparam int CNT_BITS_D   = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RESET, PH_KEY, PH_FRAME,
    PH_DISCARD, PH_BURST_A, PH_BURST_B, PH_DONE
  } phase_e;

  localparam int CTL_DATA  = 0;
  localparam int CTL_FORCE = 1;
  localparam int CTL_RESET = 2;
endpackage

// File: rtl/kss_phase_seq.sv
module kss_phase_seq
  import kss_setup_pkg::*;
#(
  parameter int KEY_BITS   = KEY_BITS_D,
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int DISCARD    = DISCARD_D,
  parameter int BURST_BITS = BURST_BITS_D,
  parameter int CNT_BITS   = CNT_BITS_D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output phase_e              phase,
  output logic [CNT_BITS-1:0] cnt
);
  localparam logic [CNT_BITS-1:0] KEY_LAST   = CNT_BITS'(KEY_BITS - 1);
  localparam logic [CNT_BITS-1:0] FRAME_LAST = CNT_BITS'(FRAME_BITS - 1);
  localparam logic [CNT_BITS-1:0] DISC_LAST  = CNT_BITS'(DISCARD - 1);
  localparam logic [CNT_BITS-1:0] BURST_LAST = CNT_BITS'(BURST_BITS - 1);

  logic [CNT_BITS-1:0] term;
  phase_e              nxt;

  always_comb begin
    unique case (phase)
      PH_KEY:     begin term = KEY_LAST;   nxt = PH_FRAME;   end
      PH_FRAME:   begin term = FRAME_LAST; nxt = PH_DISCARD; end
      PH_DISCARD: begin term = DISC_LAST;  nxt = PH_BURST_A; end
      PH_BURST_A: begin term = BURST_LAST; nxt = PH_BURST_B; end
      PH_BURST_B: begin term = BURST_LAST; nxt = PH_DONE;    end
      PH_RESET:   begin term = '0;         nxt = PH_KEY;     end
      PH_DONE:    begin term = '0;         nxt = PH_IDLE;    end
      default:    begin term = '0;         nxt = PH_IDLE;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (start) phase <= PH_RESET;
    end else if (cnt == term) begin
      cnt   <= '0;
      phase <= nxt;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_KEY_THEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_KEY && phase != PH_KEY) |-> phase == PH_FRAME); // R4
  AST_DISCARD_THEN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_DISCARD && phase != PH_DISCARD) |-> phase == PH_BURST_A); // R5
endmodule

// File: rtl/kss_ctl_drive.sv
module kss_ctl_drive
  import kss_setup_pkg::*;
#(
  parameter int KEY_BITS   = KEY_BITS_D,
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int CNT_BITS   = CNT_BITS_D
) (
  input  phase_e                phase,
  input  logic [CNT_BITS-1:0]   cnt,
  input  logic [KEY_BITS-1:0]   key_q,
  input  logic [FRAME_BITS-1:0] frame_q,
  output logic [2:0]            ctl
);
  localparam int KIDX = $clog2(KEY_BITS);
  localparam int FIDX = $clog2(FRAME_BITS);

  always_comb begin
    ctl = 3'b000;
    unique case (phase)
      PH_RESET: begin
        ctl[CTL_RESET] = 1'b1;
        ctl[CTL_DATA]  = key_q[0];
      end
      PH_KEY: begin
        ctl[CTL_FORCE] = 1'b1;
        ctl[CTL_DATA]  = key_q[cnt[KIDX-1:0]];
      end
      PH_FRAME: begin
        ctl[CTL_FORCE] = 1'b1;
        ctl[CTL_DATA]  = frame_q[cnt[FIDX-1:0]];
      end
      default: ctl = 3'b000;
    endcase
  end
endmodule

// File: rtl/kss_burst_cap.sv
module kss_burst_cap
  import kss_setup_pkg::*;
#(
  parameter int BURST_BITS = BURST_BITS_D,
  parameter int CNT_BITS   = CNT_BITS_D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  phase_e                phase,
  input  logic [CNT_BITS-1:0]   cnt,
  input  logic                  core_out,
  output logic [BURST_BITS-1:0] burst_a,
  output logic [BURST_BITS-1:0] burst_b,
  output logic                  done
);
  localparam logic [CNT_BITS-1:0] BURST_LAST = CNT_BITS'(BURST_BITS - 1);

  logic cap_q, to_b_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      to_b_q  <= 1'b0;
      last_q  <= 1'b0;
      done    <= 1'b0;
      burst_a <= '0;
      burst_b <= '0;
    end else begin
      cap_q  <= (phase == PH_BURST_A) || (phase == PH_BURST_B);
      to_b_q <= (phase == PH_BURST_B);
      last_q <= (phase == PH_BURST_B) && (cnt == BURST_LAST);
      done   <= cap_q && last_q;
      if (cap_q && !to_b_q) burst_a <= {burst_a[BURST_BITS-2:0], core_out};
      if (cap_q &&  to_b_q) burst_b <= {burst_b[BURST_BITS-2:0], core_out};
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BURST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !cap_q) |=> $stable(burst_a)); // R9
  AST_BURST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !cap_q) |=> $stable(burst_b)); // R9
endmodule

// File: rtl/kss_setup_seq.sv
module kss_setup_seq
  import kss_setup_pkg::*;
#(
  parameter int KEY_BITS   = KEY_BITS_D,
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int DISCARD    = DISCARD_D,
  parameter int BURST_BITS = BURST_BITS_D,
  parameter int CNT_BITS   = CNT_BITS_D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [KEY_BITS-1:0]   key_in,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic [2:0]            core_ctl,
  input  logic                  core_out,
  output logic [BURST_BITS-1:0] burst_ab,
  output logic [BURST_BITS-1:0] burst_ba,
  output logic                  done
);
  phase_e                phase;
  logic [CNT_BITS-1:0]   cnt;
  logic [KEY_BITS-1:0]   key_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  accept;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= '0;
      frame_q <= '0;
    end else if (accept) begin
      key_q   <= key_in;
      frame_q <= frame_in;
    end
  end

  kss_phase_seq #(
    .KEY_BITS(KEY_BITS), .FRAME_BITS(FRAME_BITS), .DISCARD(DISCARD),
    .BURST_BITS(BURST_BITS), .CNT_BITS(CNT_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .phase(phase), .cnt(cnt)
  );

  kss_ctl_drive #(
    .KEY_BITS(KEY_BITS), .FRAME_BITS(FRAME_BITS), .CNT_BITS(CNT_BITS)
  ) u_ctl (
    .phase(phase), .cnt(cnt), .key_q(key_q), .frame_q(frame_q), .ctl(core_ctl)
  );

  kss_burst_cap #(
    .BURST_BITS(BURST_BITS), .CNT_BITS(CNT_BITS)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt), .core_out(core_out),
    .burst_a(burst_ab), .burst_b(burst_ba), .done(done)
  );

  AST_ACCEPT_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (core_ctl[CTL_RESET] && core_ctl[CTL_DATA] == $past(key_in[0]))); // R2
  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_ctl[CTL_RESET] |=> !core_ctl[CTL_RESET]); // R2
  AST_FORCE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    core_ctl[CTL_FORCE] |-> !core_ctl[CTL_RESET]); // R3
  AST_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(key_q) && $stable(frame_q)); // R8
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R1
endmodule

// File: tb/kss_setup_seq_test.sv
`timescale 1ns/1ps
module kss_setup_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [63:0]  key_in = '0;
  logic [21:0]  frame_in = '0;
  logic [2:0]   core_ctl;
  logic         core_out;
  logic [113:0] burst_ab, burst_ba;
  logic         done;
  logic [63:0]  cs;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  kss_setup_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .key_in(key_in), .frame_in(frame_in), .core_ctl(core_ctl), .core_out(core_out),
    .burst_ab(burst_ab), .burst_ba(burst_ba), .done(done)
  );

  // state packing: r1 = s[18:0], r2 = s[40:19], r3 = s[63:41]
  function automatic logic [63:0] adv(input logic [63:0] s, input logic frc, input logic d);
    logic [18:0] a; logic [21:0] b; logic [22:0] c; logic m;
    a = s[18:0]; b = s[40:19]; c = s[63:41];
    m = (32'(a[8]) + 32'(b[10]) + 32'(c[10])) >= 2;
    if (frc || a[8] == m)  a = {a[17:0], d ^ a[13] ^ a[16] ^ a[17] ^ a[18]};
    if (frc || b[10] == m) b = {b[20:0], d ^ b[20] ^ b[21]};
    if (frc || c[10] == m) c = {c[21:0], d ^ c[7] ^ c[20] ^ c[21] ^ c[22]};
    return {c, b, a};
  endfunction

  function automatic logic obit(input logic [63:0] s);
    return s[18] ^ s[40] ^ s[63];
  endfunction

  always @(posedge clk) cs <= core_ctl[2] ? 64'd0 : adv(cs, core_ctl[1], core_ctl[0]);
  assign core_out = obit(cs);

  function automatic logic [227:0] expect_bursts(input logic [63:0] k, input logic [21:0] f);
    logic [63:0] s; logic [227:0] r;
    s = '0; r = '0;
    for (int i = 0; i < 64; i++)  s = adv(s, 1'b1, k[i]);
    for (int i = 0; i < 22; i++)  s = adv(s, 1'b1, f[i]);
    for (int i = 0; i < 100; i++) s = adv(s, 1'b0, 1'b0);
    for (int i = 0; i < 228; i++) begin
      s = adv(s, 1'b0, 1'b0);
      r = {r[226:0], obit(s)};
    end
    return r;
  endfunction

  function automatic logic [2:0] expect_ctl(input int idx, input logic [63:0] k, input logic [21:0] f);
    if (idx == 0)  return {2'b10, k[0]};
    if (idx <= 64) return {2'b01, k[idx-1]};
    if (idx <= 86) return {2'b01, f[idx-65]};
    return 3'b000;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [227:0] act, input logic [227:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic session(input logic [63:0] k, input logic [21:0] f);
    logic [227:0] e;
    logic bad_r2, bad_r3, bad_r4, bad_r5, bad_r7, bad_r1;
    logic [113:0] ha, hb;
    bad_r2 = 0; bad_r3 = 0; bad_r4 = 0; bad_r5 = 0; bad_r7 = 0; bad_r1 = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready before request", 228'(req_ready), 228'd1);
    key_in = k; frame_in = f; req_valid = 1'b1;
    @(negedge clk);
    for (int idx = 0; idx < 416; idx++) begin
      if (core_ctl !== expect_ctl(idx, k, f)) begin
        if (idx == 0) bad_r2 = 1;
        else if (idx <= 64) bad_r3 = 1;
        else if (idx <= 86) bad_r4 = 1;
        else bad_r5 = 1;
      end
      if (idx == 1 && core_ctl[2] !== 1'b0) bad_r2 = 1;
      if (done !== 1'b0) bad_r7 = 1;
      if (req_ready !== 1'b0) bad_r1 = 1;
      key_in = {$urandom, $urandom};    // R8: scrambled after acceptance
      frame_in = 22'($urandom);
      req_valid = (idx < 415) ? 1'($urandom) : 1'b0;
      @(negedge clk);
    end
    chk(!bad_r1, "R1 ready low while busy", 228'(bad_r1), 228'd0);
    chk(!bad_r2, "R2 reset cycle", 228'(bad_r2), 228'd0);
    chk(!bad_r3, "R3 key cycles", 228'(bad_r3), 228'd0);
    chk(!bad_r4, "R4 frame cycles", 228'(bad_r4), 228'd0);
    chk(!bad_r5, "R5 idle control", 228'(bad_r5), 228'd0);
    chk(!bad_r7, "R7 no early done", 228'(bad_r7), 228'd0);
    chk(done === 1'b1 && req_ready === 1'b1, "R7 done at 417", 228'({done, req_ready}), 228'd3);
    e = expect_bursts(k, f);
    chk(burst_ab === e[227:114], "R6 R8 burst_ab", 228'(burst_ab), 228'(e[227:114]));
    chk(burst_ba === e[113:0], "R6 R8 burst_ba", 228'(burst_ba), 228'(e[113:0]));
    ha = burst_ab; hb = burst_ba;
    @(negedge clk);
    chk(done === 1'b0, "R7 done single cycle", 228'(done), 228'd0);
    for (int i = 0; i < 8; i++) @(negedge clk);
    chk(burst_ab === ha && burst_ba === hb, "R9 bursts held idle", 228'({burst_ab, burst_ba}), 228'({ha, hb}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0 || req_ready === 1'b1, "R1 reset ready defined", 228'(req_ready), 228'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && core_ctl === 3'b000, "R1 reset state",
        228'({req_ready, done, core_ctl}), 228'({1'b1, 1'b0, 3'b000}));
    chk(burst_ab === '0 && burst_ba === '0, "R9 reset bursts", 228'({burst_ab, burst_ba}), 228'd0);
    $urandom(32'd1234);
    session(64'hEFCDAB8967452312, 22'h000134);
    session(64'd0, 22'd0);
    session({64{1'b1}}, {22{1'b1}});
    session(64'h1, 22'h200000);
    for (int n = 0; n < 4; n++) session({$urandom, $urandom}, 22'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule